// File: doc/BRIEF.md
# DMA External Request Acceptance Logic

This block sits between an active-low external DMA request pin and a DMA channel engine. It brings the pin into the clock domain, samples it every cycle while acceptance is open, and turns a low sample into a request that stays held until the engine reports that activation has started. After that it withholds acceptance for a clearance period before the next request may be taken.

Two sensing modes are offered. In edge mode the block resumes acceptance only after two things: the engine's single cycle has completed, and the synchronized pin has been seen high again. A pin that stays low therefore yields one request per falling edge. In level mode only the completed single cycle is needed, so a pin held low produces back-to-back requests. A configuration write opens acceptance. Reset, a disabling write or a transfer-end indication closes it and drops any held request.

Top module: `dxr_accept_top`

## Requirements
- R1: After reset, and at any time while the channel is disabled, `req_pending` and `accept_en` are 0 and a low `dreq_n` raises no request.
- R2: A cycle with `cfg_we`=1 and `cfg_enable`=1 on a disabled channel sets `accept_en` to 1 on the next rising clock edge.
- R3: `dreq_n` passes two synchronizer flops before it is sampled. A low value present before edge N, with acceptance open, sets `req_pending` to 1 and clears `accept_en` after edge N+2.
- R4: A held request stays set, whatever the pin does, until `act_start` is seen.
- R5: `act_start` while a request is held clears `req_pending` on the next edge and starts the clearance period, with `accept_en` still 0.
- R6: In edge mode (`mode_level`=0), acceptance resumes only once `cycle_done` has been seen and a high synchronized pin level has been seen since the clear. If the high level is seen by the `cycle_done` edge, acceptance opens at that edge. A pin that stays low never reopens acceptance.
- R7: In edge mode, if the high level is first seen after `cycle_done`, `accept_en` rises on the edge at which the synchronized high is first sampled.
- R8: In level mode (`mode_level`=1), acceptance resumes after `cycle_done` without any high level. With the pin held low, a new request is held on the edge after acceptance reopens.
- R9: From the edge that clears `req_pending` until `accept_en` rises again, at least MIN_CLEAR (default 3) clock cycles pass, even when `cycle_done` arrives earlier.
- R10: `xfer_end`=1, a write with `cfg_enable`=0, or reset clears `req_pending` and `accept_en` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Channel enable write strobe |
| cfg_enable | input | 1 | Enable value written with `cfg_we` |
| mode_level | input | 1 | 1 = level sensing, 0 = falling-edge sensing |
| dreq_n | input | 1 | Raw external request pin, active low |
| act_start | input | 1 | Pulse from engine: activation started |
| cycle_done | input | 1 | Pulse from engine: single cycle completed |
| xfer_end | input | 1 | Transfer end, closes the channel |
| req_pending | output | 1 | Request held for the engine |
| accept_en | output | 1 | Pin sampling for new requests is open |

## Verification
The checker watches a set of rules on every cycle. A request may appear only out of an open acceptance state. A held request persists until activation and clears right after it. Transfer end and disabling writes close everything. Reopening never comes sooner than the clearance minimum after a clear. The bench scenarios are needed for everything that depends on the pin's history and the sensing mode: the two-flop latency, re-arming on the pin's high level in edge mode (including a high that arrives only after the cycle ends), back-to-back requests in level mode, and a pin stuck low never re-arming edge mode.

// File: rtl/dxr_pkg.sv
package dxr_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_OPEN  = 2'd1,
        ST_HELD  = 2'd2,
        ST_CLEAR = 2'd3
    } dxr_state_e;

    typedef struct packed {
        dxr_state_e st;
        logic       en;
        logic       hi_seen;
        logic       done_seen;
    } dxr_regs_t;
endpackage

// File: rtl/dxr_sync.sv
module dxr_sync #(
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= RST_VAL;
                else        sh_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= {STAGES{RST_VAL}};
                else        sh_q <= {sh_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/dxr_clear_timer.sv
module dxr_clear_timer #(
    parameter int MIN_CLEAR = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ok
);
    localparam int CW = (MIN_CLEAR > 2) ? $clog2(MIN_CLEAR) : 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_CLEAR - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)             cnt_d = '0;
        else if (cnt_q < LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LAST;
        else        cnt_q <= cnt_d;
    end

    assign ok = (cnt_q >= LAST);
endmodule

// File: rtl/dxr_accept_top.sv
module dxr_accept_top
    import dxr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CLEAR   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_enable,
    input  logic mode_level,
    input  logic dreq_n,
    input  logic act_start,
    input  logic cycle_done,
    input  logic xfer_end,
    output logic req_pending,
    output logic accept_en
);
    dxr_regs_t r_d, r_q;
    logic pin_s;
    logic tmr_start, tmr_ok;
    logic hi_now, done_now;

    dxr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (dreq_n),
        .dout (pin_s)
    );

    dxr_clear_timer #(.MIN_CLEAR(MIN_CLEAR)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_start),
        .ok   (tmr_ok)
    );

    always_comb begin
        r_d       = r_q;
        tmr_start = 1'b0;
        hi_now    = r_q.hi_seen | pin_s;
        done_now  = r_q.done_seen | cycle_done;
        unique case (r_q.st)
            ST_OFF: begin
            end
            ST_OPEN: begin
                if (!pin_s) r_d.st = ST_HELD;
            end
            ST_HELD: begin
                if (act_start) begin
                    r_d.st        = ST_CLEAR;
                    r_d.hi_seen   = 1'b0;
                    r_d.done_seen = 1'b0;
                    tmr_start     = 1'b1;
                end
            end
            ST_CLEAR: begin
                r_d.hi_seen   = hi_now;
                r_d.done_seen = done_now;
                if (done_now && tmr_ok && (mode_level || hi_now))
                    r_d.st = ST_OPEN;
            end
        endcase
        if (cfg_we) begin
            if (cfg_enable) begin
                if (!r_q.en) r_d.st = ST_OPEN;
                r_d.en = 1'b1;
            end else begin
                r_d.en = 1'b0;
                r_d.st = ST_OFF;
            end
        end
        if (xfer_end) begin
            r_d.en = 1'b0;
            r_d.st = ST_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_OFF;
            r_q.en        <= 1'b0;
            r_q.hi_seen   <= 1'b0;
            r_q.done_seen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_pending = (r_q.st == ST_HELD);
    assign accept_en   = (r_q.st == ST_OPEN);
endmodule

// File: rtl/dxr_accept_chk.sv
module dxr_accept_chk #(
    parameter int MIN_CLEAR = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic cfg_enable,
    input logic act_start,
    input logic xfer_end,
    input logic req_pending,
    input logic accept_en
);
    localparam int GW = $clog2(MIN_CLEAR + 1) + 1;
    localparam logic [GW-1:0] GMAX = GW'(MIN_CLEAR);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               gap_q <= GMAX;
        else if (req_pending)     gap_q <= '0;
        else if (gap_q < GMAX)    gap_q <= gap_q + 1'b1;
    end

    AST_REQ_FROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_pending) |-> $past(accept_en)); // R3

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        req_pending && !act_start && !xfer_end && !cfg_we |=> req_pending); // R4

    AST_ACT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        req_pending && act_start && !cfg_we |=> !req_pending && !accept_en); // R5

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_en) && !$past(cfg_we) |-> gap_q >= GMAX); // R9

    AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end || (cfg_we && !cfg_enable) |=> !req_pending && !accept_en); // R10
endmodule

bind dxr_accept_top dxr_accept_chk #(.MIN_CLEAR(MIN_CLEAR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_enable (cfg_enable),
    .act_start  (act_start),
    .xfer_end   (xfer_end),
    .req_pending(req_pending),
    .accept_en  (accept_en)
);

// File: tb/dxr_accept_top_test.sv
`timescale 1ns/1ps
module dxr_accept_top_test;
    logic clk = 1'b0;
    logic rst_n, cfg_we, cfg_enable, mode_level, dreq_n, act_start, cycle_done, xfer_end;
    logic req_pending, accept_en;
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dxr_accept_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
        .mode_level(mode_level), .dreq_n(dreq_n), .act_start(act_start),
        .cycle_done(cycle_done), .xfer_end(xfer_end),
        .req_pending(req_pending), .accept_en(accept_en)
    );

    // {we, en, mode, pin, act, done, xend, exp_req, exp_acc}
    localparam int NV = 31;
    localparam logic [8:0] VEC [NV] = '{
        9'b110100001, // 0  R2 enable, edge mode
        9'b000000001, // 1  R3 pin low enters sync
        9'b000000001, // 2  R3
        9'b000000010, // 3  R3 request held
        9'b000010000, // 4  R5 activation clears
        9'b000100000, // 5  R9
        9'b000100000, // 6  R9
        9'b000101001, // 7  R6 high seen by done: reopen
        9'b000000001, // 8
        9'b000000001, // 9
        9'b000000010, // 10 R3
        9'b000010000, // 11 R5
        9'b000001000, // 12 R7 done, pin still low
        9'b000000000, // 13 R7
        9'b000100000, // 14 R7
        9'b000100000, // 15 R7
        9'b000100001, // 16 R7 high after done: reopen
        9'b000100100, // 17 R10 transfer end
        9'b111000001, // 18 R2 enable, level mode
        9'b001000001, // 19 R8
        9'b001000010, // 20 R8
        9'b001010000, // 21 R5
        9'b001001000, // 22 R9 done early, clearance not over
        9'b001000000, // 23 R9
        9'b001000001, // 24 R9 reopen after 3 cycles
        9'b001000010, // 25 R8 back-to-back
        9'b001010000, // 26 R5
        9'b101000000, // 27 R10 disable write
        9'b001000000, // 28 R1 disabled, pin low
        9'b001000000, // 29 R1
        9'b001000000  // 30 R1
    };
    localparam int TAG [NV] = '{2,3,3,3,5,9,9,6,3,3,3,5,7,7,7,7,7,10,2,8,8,5,9,9,9,8,5,10,1,1,1};

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic idle_in();
        cfg_we = 0; cfg_enable = 0; act_start = 0; cycle_done = 0; xfer_end = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 0; mode_level = 0; dreq_n = 1; idle_in();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", req_pending, 1'b0, "req after reset");
        chk("R1", accept_en, 1'b0, "acc after reset");

        for (int i = 0; i < NV; i++) begin
            {cfg_we, cfg_enable, mode_level, dreq_n, act_start, cycle_done, xfer_end} = VEC[i][8:2];
            @(negedge clk);
            chk($sformatf("R%0d", TAG[i]), req_pending, VEC[i][1], $sformatf("req vec %0d", i));
            chk($sformatf("R%0d", TAG[i]), accept_en, VEC[i][0], $sformatf("acc vec %0d", i));
        end

        // Edge mode, pin stuck low: held request persists, then never re-arms
        idle_in(); mode_level = 0; dreq_n = 0; cfg_we = 1; cfg_enable = 1;
        @(negedge clk);
        idle_in();
        @(negedge clk);
        chk("R3", req_pending, 1'b1, "req with pin already low");
        repeat (5) @(negedge clk);
        chk("R4", req_pending, 1'b1, "held without activation");
        act_start = 1;
        @(negedge clk);
        act_start = 0; cycle_done = 1;
        @(negedge clk);
        cycle_done = 0;
        repeat (6) @(negedge clk);
        chk("R6", accept_en, 1'b0, "stuck-low pin must not reopen");
        chk("R6", req_pending, 1'b0, "stuck-low pin no request");

        // Reset while held
        dreq_n = 1;
        repeat (3) @(negedge clk);
        dreq_n = 0; cfg_we = 1; cfg_enable = 0;
        @(negedge clk);
        cfg_we = 1; cfg_enable = 1;
        @(negedge clk);
        idle_in();
        repeat (3) @(negedge clk);
        chk("R3", req_pending, 1'b1, "held before reset");
        rst_n = 0;
        @(negedge clk);
        chk("R10", req_pending, 1'b0, "req cleared by reset");
        chk("R10", accept_en, 1'b0, "acc cleared by reset");
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk("R1", req_pending, 1'b0, "no req after reset, pin low");
        chk("R1", accept_en, 1'b0, "no acc after reset");

        summary();
    end
endmodule